// File: doc/BRIEF.md
# Multi-Channel Sample Bit Packer

The block samples sixteen logic input pins each time a sample strobe is high. For each channel it collects sixteen successive samples into one 16-bit word. When sixteen strobes have made up a group, the words of the enabled channels go out as a byte stream on a valid/ready interface that feeds a USB FIFO. The words leave in ascending channel order, and each word is sent low byte first. A channel enable mask, given as two bytes, chooses which channels are sent.

A finished group is copied into a holding buffer, so capture of the next group runs while the previous one drains. When the buffer is still draining at the moment a new group completes, the new group is discarded and a sticky overflow flag is raised. The host sees groups that are whole or missing, never partly overwritten.

Top module: `chan_packer`

## Requirements
- R1: Synchronous active-high reset clears the sample count, empties the holding buffer (`out_valid` low) and clears `ovf`. After reset, the sixteenth strobe completes the first group.
- R2: Each cycle with `smp_stb` high takes one sample of every pin (1 = high, 0 = low). In a channel word, bit k holds the level at the k-th strobe of the group, so bit 0 is the oldest sample and bit 15 the newest.
- R3: Each word is sent as two bytes: bits 7:0 first, then bits 15:8.
- R4: Channel c is enabled when bit c of the mask {`en_hi`,`en_lo`} is 1. `en_lo` covers channels 0 to 7 and `en_hi` covers channels 8 to 15. The words of a group go out in ascending channel order, starting at the lowest enabled channel. The mask is taken on the strobe that completes the group.
- R5: Disabled channels produce no bytes. A group taken with an all-zero mask produces no bytes and leaves the holding buffer free.
- R6: The masks 0x0007, 0x003F, 0x01FF and 0xFFFF (3, 6, 9 and 16 channels) yield 6, 12, 18 and 32 bytes per group.
- R7: A byte transfers on a cycle when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R8: The first byte of an accepted group is on `out_data` with `out_valid` high in the cycle after the completing strobe. Capture goes on while the buffer drains. A new group is accepted when the buffer is empty, or when its last byte transfers in the same cycle that the new group completes.
- R9: A group that completes while the buffer is still draining (any mask) is dropped. The group being drained is not affected, and `ovf` goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe; one sample of every pin per high cycle |
| pins | input | 16 | Logic levels of the sixteen channels |
| en_lo | input | 8 | Enable bits for channels 0 to 7 |
| en_hi | input | 8 | Enable bits for channels 8 to 15 |
| out_ready | input | 1 | Downstream FIFO accepts a byte |
| out_valid | output | 1 | A byte is offered on out_data |
| out_data | output | 8 | Output byte |
| ovf | output | 1 | Sticky flag: a completed group was dropped |

## Verification
The bench sends groups with 16 strobes back to back and an eight-channel mask. The buffer then empties in exactly the cycle the next group completes. A design that treats that cycle as busy raises a false overflow, and one that loads the buffer too early corrupts the last byte. Nine channels at full strobe rate must overflow without disturbing the group being drained. A design that overwrites the buffer shows wrong bytes, and one with a non-sticky flag drops `ovf`. Sparse and zero masks, reset in the middle of a group, and random stalls on `out_ready` catch channel skipping errors, byte swaps, a sample count that survives reset, and data that changes while a byte waits.

// File: rtl/chan_pack_pkg.sv
package chan_pack_pkg;
    localparam int NUM_CH         = 16;
    localparam int SMP_PER_WORD   = 16;
    localparam int BYTE_W         = 8;
    localparam int BYTES_PER_WORD = SMP_PER_WORD / BYTE_W;
    localparam int NUM_BYTES      = NUM_CH * BYTES_PER_WORD;
    localparam int CH_IDX_W       = $clog2(NUM_CH);
    localparam int CNT_W          = $clog2(SMP_PER_WORD);
    localparam int SEL_W          = (BYTES_PER_WORD > 1) ? $clog2(BYTES_PER_WORD) : 1;

    typedef logic [SMP_PER_WORD-1:0]      word_t;
    typedef logic [NUM_CH-1:0]            mask_t;
    typedef logic [CH_IDX_W-1:0]          idx_t;
    typedef logic [SEL_W-1:0]             sel_t;
    typedef logic [BYTE_W-1:0]            byte_t;
    typedef word_t [NUM_CH-1:0]           group_t;

    localparam sel_t SEL_LAST = sel_t'(BYTES_PER_WORD - 1);

    typedef struct packed {
        logic found;
        idx_t idx;
    } pick_t;

    typedef struct packed {
        idx_t ch;
        sel_t sel;
    } cursor_t;

    // lowest set bit of m at or above position from
    function automatic pick_t first_from(mask_t m, int unsigned from);
        pick_t res;
        res = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (m[c] && (c >= int'(from))) begin
                res.found = 1'b1;
                res.idx   = idx_t'(c);
            end
        end
        return res;
    endfunction
endpackage

// File: rtl/pk_capture.sv
module pk_capture
    import chan_pack_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   smp_stb,
    input  mask_t  pins,
    output logic   grp_done,
    output group_t grp_words
);
    group_t           words_q;
    logic [CNT_W-1:0] cnt_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        // newest sample enters at the top, oldest ends at bit 0
        assign grp_words[c] = {pins[c], words_q[c][SMP_PER_WORD-1:1]};
    end

    assign grp_done = smp_stb && (cnt_q == CNT_W'(SMP_PER_WORD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
            cnt_q   <= '0;
        end else if (smp_stb) begin
            words_q <= grp_words;
            cnt_q   <= grp_done ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pk_drain.sv
module pk_drain
    import chan_pack_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    grp_done,
    input  group_t  grp_words,
    input  mask_t   grp_mask,
    input  logic    out_ready,
    output logic    busy,
    output cursor_t cur,
    output group_t  hold,
    output mask_t   held_mask,
    output logic    ovf
);
    pick_t nxt;
    pick_t start;
    logic  xfer;
    logic  last_xfer;
    logic  free;

    always_comb begin
        nxt       = first_from(held_mask, 32'(cur.ch) + 32'd1);
        start     = first_from(grp_mask, 32'd0);
        xfer      = busy && out_ready;
        last_xfer = xfer && (cur.sel == SEL_LAST) && !nxt.found;
        free      = !busy || last_xfer;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cur       <= '0;
            hold      <= '0;
            held_mask <= '0;
            ovf       <= 1'b0;
        end else begin
            if (xfer) begin
                if (cur.sel != SEL_LAST) begin
                    cur.sel <= cur.sel + 1'b1;
                end else if (nxt.found) begin
                    cur.ch  <= nxt.idx;
                    cur.sel <= '0;
                end else begin
                    busy <= 1'b0;
                end
            end
            if (grp_done) begin
                if (free) begin
                    hold      <= grp_words;
                    held_mask <= grp_mask;
                    busy      <= start.found;
                    cur.ch    <= start.idx;
                    cur.sel   <= '0;
                end else begin
                    ovf <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pk_outmux.sv
module pk_outmux
    import chan_pack_pkg::*;
(
    input  group_t  hold,
    input  cursor_t cur,
    output byte_t   out_byte
);
    byte_t flat [NUM_BYTES];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_byte
            assign flat[c * BYTES_PER_WORD + b] = hold[c][b*BYTE_W +: BYTE_W];
        end
    end

    assign out_byte = flat[{cur.ch, cur.sel}];
endmodule

// File: rtl/chan_packer.sv
module chan_packer
    import chan_pack_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_stb,
    input  logic [15:0] pins,
    input  logic [7:0]  en_lo,
    input  logic [7:0]  en_hi,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        ovf
);
    logic    grp_done;
    group_t  grp_words;
    group_t  hold;
    mask_t   held_mask;
    cursor_t cur;
    logic    busy;
    idx_t    cur_ch;
    sel_t    cur_sel;

    pk_capture i_capture (
        .clk       (clk),
        .rst       (rst),
        .smp_stb   (smp_stb),
        .pins      (pins),
        .grp_done  (grp_done),
        .grp_words (grp_words)
    );

    pk_drain i_drain (
        .clk       (clk),
        .rst       (rst),
        .grp_done  (grp_done),
        .grp_words (grp_words),
        .grp_mask  ({en_hi, en_lo}),
        .out_ready (out_ready),
        .busy      (busy),
        .cur       (cur),
        .hold      (hold),
        .held_mask (held_mask),
        .ovf       (ovf)
    );

    pk_outmux i_outmux (
        .hold     (hold),
        .cur      (cur),
        .out_byte (out_data)
    );

    assign out_valid = busy;
    assign cur_ch    = cur.ch;
    assign cur_sel   = cur.sel;
endmodule

// File: rtl/chan_pack_chk.sv
module chan_pack_chk
    import chan_pack_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_data,
    input logic       ovf,
    input idx_t       cur_ch,
    input sel_t       cur_sel,
    input mask_t      held_mask
);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R5: only enabled channels are ever offered
    p_enabled_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> held_mask[cur_ch]);

    p_lowfirst_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && (cur_sel != SEL_LAST)
        |=> out_valid && $stable(cur_ch) && (cur_sel == $past(cur_sel) + 1'b1));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
endmodule

bind chan_packer chan_pack_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .ovf       (ovf),
    .cur_ch    (cur_ch),
    .cur_sel   (cur_sel),
    .held_mask (held_mask)
);

// File: tb/test_chan_packer.sv
module test_chan_packer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_stb = 1'b0;
    logic [15:0] pins = '0;
    logic [7:0]  en_lo = '0;
    logic [7:0]  en_hi = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        ovf;

    chan_packer i_chan_packer (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .pins(pins),
        .en_lo(en_lo), .en_hi(en_hi), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .ovf(ovf)
    );

    always #4 clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    logic [7:0]  exp_q[$];
    bit          exp_ovf = 0;
    int          cnt = 0;
    logic [15:0] smp [16];
    string       ctx = "R2";

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_mask(logic [15:0] m);
        en_lo = m[7:0];
        en_hi = m[15:8];
    endtask

    // expected stream of a completed group, built from the requirements
    task automatic complete_group();
        logic [15:0] m;
        logic [15:0] w;
        m = {en_hi, en_lo};
        if (exp_q.size() == 0) begin
            for (int c = 0; c < 16; c++) begin
                if (m[c]) begin
                    for (int k = 0; k < 16; k++) w[k] = smp[k][c];
                    exp_q.push_back(w[7:0]);
                    exp_q.push_back(w[15:8]);
                end
            end
        end else begin
            exp_ovf = 1;
        end
    endtask

    // called just after a falling edge
    task automatic tick(bit stb, logic [15:0] p, bit rdy);
        bit has;
        has = exp_q.size() > 0;
        chk(out_valid === has, {ctx, " valid"}, 32'(out_valid), 32'(has));
        if (has && out_valid === 1'b1)
            chk(out_data === exp_q[0], {ctx, " data"}, 32'(out_data), 32'(exp_q[0]));
        chk(ovf === exp_ovf, "R9 ovf", 32'(ovf), 32'(exp_ovf));
        smp_stb   = stb;
        pins      = p;
        out_ready = rdy;
        @(posedge clk);
        if (has && rdy) void'(exp_q.pop_front());
        if (stb) begin
            smp[cnt] = p;
            cnt++;
            if (cnt == 16) begin
                cnt = 0;
                complete_group();
            end
        end
        @(negedge clk);
    endtask

    function automatic bit coin(int pct);
        return $urandom_range(99) < pct;
    endfunction

    task automatic idle(int n, int rdy_pct);
        for (int i = 0; i < n; i++) tick(1'b0, 16'($urandom), coin(rdy_pct));
    endtask

    task automatic run_group(int gap, int rdy_pct);
        for (int s = 0; s < 16; s++) begin
            tick(1'b1, 16'($urandom), coin(rdy_pct));
            for (int g = 0; g < gap; g++) tick(1'b0, 16'($urandom), coin(rdy_pct));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_stb = 1'b0;
        out_ready = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        exp_ovf = 0;
        cnt = 0;
        chk(out_valid === 1'b0, "R1 valid after reset", 32'(out_valid), 0);
        chk(ovf === 1'b0, "R1 ovf after reset", 32'(ovf), 0);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] masks [4];
        masks[0] = 16'h0007; masks[1] = 16'h003F; masks[2] = 16'h01FF; masks[3] = 16'hFFFF;
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        do_reset();

        // R2: channel 0 high only on the first strobe, channel 1 only on the last
        ctx = "R2";
        set_mask(16'h0003);
        for (int s = 0; s < 16; s++)
            tick(1'b1, (s == 0) ? 16'h0001 : ((s == 15) ? 16'h0002 : 16'h0000), 1'b1);
        // R3: bytes appear 01 00 00 80
        ctx = "R3";
        idle(8, 100);

        // R6: the four supported channel counts
        ctx = "R6";
        for (int i = 0; i < 4; i++) begin
            set_mask(masks[i]);
            run_group(2, 100);
            idle(40, 100);
        end

        // R4 / R5: sparse masks across both enable bytes, and a zero mask
        ctx = "R4";
        set_mask(16'h8001); run_group(0, 100); idle(10, 100);
        set_mask(16'h0100); run_group(1, 100); idle(10, 100);
        ctx = "R5";
        set_mask(16'h0000); run_group(0, 100); idle(5, 100);
        set_mask(16'h0000); run_group(0, 100); idle(5, 100);
        chk(out_valid === 1'b0 && ovf === 1'b0, "R5 zero mask silent", 32'({out_valid, ovf}), 0);

        // R7: stalls on ready
        ctx = "R7";
        set_mask(16'h5A5A); run_group(3, 30); idle(80, 30);

        // R1: reset in mid group restarts the sample count
        ctx = "R1";
        set_mask(16'h000F);
        for (int s = 0; s < 5; s++) tick(1'b1, 16'($urandom), 1'b1);
        do_reset();
        set_mask(16'h000F); run_group(0, 100); idle(12, 100);

        // R8: 16 bytes per 16 strobes: buffer frees exactly as next group lands
        ctx = "R8";
        set_mask(16'h00FF);
        for (int g = 0; g < 4; g++) run_group(0, 100);
        idle(20, 100);
        chk(ovf === 1'b0, "R8 no overflow at exact boundary", 32'(ovf), 0);

        // R9: 18 bytes per 16 strobes must overflow
        ctx = "R9";
        set_mask(16'h01FF);
        run_group(0, 100); run_group(0, 100);
        idle(30, 100);
        chk(ovf === 1'b1, "R9 overflow sticky", 32'(ovf), 1);
        do_reset();

        // random mix
        ctx = "R4";
        for (int g = 0; g < 150; g++) begin
            if (coin(50)) set_mask(masks[$urandom_range(3)]);
            else set_mask(16'($urandom));
            run_group($urandom_range(2), 40 + $urandom_range(60));
            if (coin(20)) idle(40, 100);
            if (coin(5)) do_reset();
        end
        idle(60, 100);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule